// File: doc/BRIEF.md
# Manchester Vehicle-Bus Frame Transmitter

This block sends one complete vehicle-bus frame on a single-wire line. The frame type (master or slave) and a 16, 32 or 64 bit payload come either with the request itself or from a small word-wide shared buffer. For the buffer path, the block reads a run of consecutive 16-bit words that starts at a given address, before the frame begins. The output `line_out` changes at half-bit-cell resolution. It carries, in order, a 9-symbol start delimiter chosen by frame type, the payload in Biphase-L Manchester code, an 8-bit check sequence, and a non-data end level. After that the line returns to its low idle level.

A transmit state machine drives the delimiter and end symbols. These symbols break the Manchester rule, so a plain bit encoder could not produce them. Each half-bit cell lasts `CELL_CLKS` clock cycles. `busy` is high from the cycle after a request is accepted until the line is back at idle. `done` marks that return with a one-cycle pulse.

Top module: `mtx_frame_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `line_out`, `busy`, `done` and `buf_rd_en` are all 0.
- R2: A request (`req_valid` high) is accepted only in a cycle where `busy` is low, and `busy` is high in the next cycle. A request seen while `busy` is high is dropped. It is not queued and does not change the frame in progress.
- R3: Every half-bit cell lasts `CELL_CLKS` clocks. For a direct request, the first cell starts in the cycle after acceptance. For a buffer request, it starts after `N+1` load cycles, where N is the number of 16-bit words.
- R4: The start delimiter is 9 symbols taken from `MASTER_DELIM` (when `req_master`=1) or `SLAVE_DELIM`. Each symbol is a 2-bit code, and the first symbol sent is bits [17:16]. The codes are 00 = data 0, 01 = data 1, 10 = non-data high, 11 = non-data low.
- R5: Data 1 is sent as high then low, and data 0 as low then high. A non-data symbol holds one level for both cells of its bit time.
- R6: `req_len` selects the payload size: 00 = 16 bits, 01 = 32 bits, 10 or 11 = 64 bits. A direct payload is the low bits of `req_data`, sent most significant bit first.
- R7: A buffer request reads addresses `req_buf_addr+k` (modulo 2^BUF_AW) for k = 0..N-1 on consecutive cycles with `buf_rd_en` high. Data arrives one cycle after each read. Word 0 forms the most significant bits of the payload. `buf_rd_en` is low at all other times.
- R8: After the payload, 8 check bits are sent MSB first. A 7-bit register r starts at 0. For each payload bit b, in send order: f = b^r[6], then r = {r[5:0],0} ^ (f ? `CHECK_POLY` : 0). The check byte is the bitwise inverse of {r, XOR-reduce(r)}.
- R9: After the check bits, the line holds `END_HIGH` for `END_CELLS` cells and then returns to 0. The line is 0 whenever `busy` is low.
- R10: `done` is high for exactly one cycle: the first cycle with the line back at idle and `busy` low. A request in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Frame request |
| req_master | input | 1 | 1 = master frame, 0 = slave frame |
| req_len | input | 2 | Payload size code |
| req_from_buf | input | 1 | 1 = payload read from the shared buffer |
| req_data | input | 64 | Direct payload, low bits used |
| req_buf_addr | input | BUF_AW | First buffer word address |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_addr | output | BUF_AW | Buffer read address |
| buf_rdata | input | 16 | Buffer read data, one cycle after the strobe |
| line_out | output | 1 | Coded line level |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two events can fall in the same cycle: the `done` pulse that ends one frame, and a new request. The bench provokes this by chaining frames with no gap, so the next request is driven in exactly the cycle when `done` is high. It then expects the new frame's first cell one cycle later, or after the buffer load, with no idle cell in between. A request is also injected while the frame is running and is judged dropped in two ways. The running frame must still match the expected cell stream cell by cell, and the gap cycles that follow must show `busy` low and the line idle.

// File: rtl/mtx_pkg.sv
// Shared types for the Manchester frame transmitter.
// Assumes: buffer word and direct payload widths are fixed by the frame format.
package mtx_pkg;
    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_ONE  = 2'b01,
        SYM_NDH  = 2'b10,
        SYM_NDL  = 2'b11
    } sym_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_DELIM, ST_DATA, ST_CHECK, ST_TAIL
    } tx_state_t;

    localparam int WORD_W     = 16;
    localparam int MAX_BITS   = 64;
    localparam int DELIM_SYMS = 9;
    localparam int CHECK_BITS = 8;
endpackage

// File: rtl/mtx_cell_timer.sv
// Half-bit cell timer: pulses tick on the last clock of every cell.
// Assumes: restart holds the count at zero so a new cell starts cleanly.
module mtx_cell_timer #(
    parameter int CELL_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CELL_CLKS > 1) ? $clog2(CELL_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CELL_CLKS - 1);

    logic [CW-1:0] cnt;

    // Count clocks within the current cell.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/mtx_sym_enc.sv
// Symbol to line-level encoder for one half-bit cell.
// Assumes: half = 0 is the first cell of the bit time.
module mtx_sym_enc
    import mtx_pkg::*;
(
    input  sym_t sym,
    input  logic half,
    output logic level
);
    // Biphase-L for data, constant level for non-data symbols.
    always_comb begin
        unique case (sym)
            SYM_ZERO: level = half;
            SYM_ONE:  level = ~half;
            SYM_NDH:  level = 1'b1;
            default:  level = 1'b0;
        endcase
    end
endmodule

// File: rtl/mtx_check_gen.sv
// Serial 7-bit cyclic check with appended parity, output inverted.
// Assumes: one shift per payload bit, MSB first; clear while idle.
module mtx_check_gen #(
    parameter logic [6:0] POLY = 7'h65
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift_en,
    input  logic       din,
    output logic [7:0] check
);
    logic [6:0] r;
    logic       fb;

    assign fb = din ^ r[6];

    // Advance the check register by one payload bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) r <= '0;
        else if (shift_en)   r <= {r[5:0], 1'b0} ^ (fb ? POLY : 7'h00);
    end

    assign check = ~{r, ^r};
endmodule

// File: rtl/mtx_frame_tx.sv
// Frame transmitter top: accepts a request, optionally preloads payload
// words from a shared buffer, then serialises delimiter, payload, check
// byte and end level onto line_out.
// Assumes: buffer read latency of one clock; requests while busy are dropped.
module mtx_frame_tx
    import mtx_pkg::*;
#(
    parameter int          BUF_AW       = 4,
    parameter int          CELL_CLKS    = 2,
    parameter int          END_CELLS    = 3,
    parameter bit          END_HIGH     = 1'b1,
    parameter logic [17:0] MASTER_DELIM = 18'b01_10_11_01_10_11_00_00_00,
    parameter logic [17:0] SLAVE_DELIM  = 18'b01_01_01_11_10_01_11_10_00,
    parameter logic [6:0]  CHECK_POLY   = 7'h65
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_master,
    input  logic [1:0]        req_len,
    input  logic              req_from_buf,
    input  logic [63:0]       req_data,
    input  logic [BUF_AW-1:0] req_buf_addr,
    output logic              buf_rd_en,
    output logic [BUF_AW-1:0] buf_addr,
    input  logic [15:0]       buf_rdata,
    output logic              line_out,
    output logic              busy,
    output logic              done
);
    localparam logic [7:0] DELIM_LAST = 8'(DELIM_SYMS - 1);
    localparam logic [7:0] CHECK_LAST = 8'(CHECK_BITS - 1);
    localparam logic [7:0] TAIL_LAST  = 8'(END_CELLS - 1);

    tx_state_t         state;
    logic              half;
    logic [7:0]        idx;
    logic [7:0]        bits_last;
    logic [1:0]        words_last;
    logic [2:0]        rk;
    logic [1:0]        wk;
    logic              rd_pend;
    logic              is_master;
    logic [BUF_AW-1:0] base;
    logic [MAX_BITS-1:0] shreg;
    logic              tick;
    logic [7:0]        check;
    logic [17:0]       dsh;
    sym_t              sym;

    mtx_cell_timer #(.CELL_CLKS(CELL_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .restart(state == ST_IDLE || state == ST_LOAD),
        .tick(tick)
    );

    mtx_check_gen #(.POLY(CHECK_POLY)) u_check (
        .clk(clk), .rst_n(rst_n),
        .clear(state == ST_IDLE),
        .shift_en(state == ST_DATA && tick && half),
        .din(shreg[MAX_BITS-1]),
        .check(check)
    );

    mtx_sym_enc u_enc (.sym(sym), .half(half), .level(line_out));

    assign busy      = (state != ST_IDLE);
    assign buf_rd_en = (state == ST_LOAD) && (rk <= {1'b0, words_last});
    assign buf_addr  = base + BUF_AW'(rk);

    // Pick the symbol for the current bit time from state and position.
    always_comb begin
        dsh = (is_master ? MASTER_DELIM : SLAVE_DELIM) << {idx[3:0], 1'b0};
        unique case (state)
            ST_DELIM: sym = sym_t'(dsh[17:16]);
            ST_DATA:  sym = shreg[MAX_BITS-1] ? SYM_ONE : SYM_ZERO;
            ST_CHECK: sym = check[3'd7 - idx[2:0]] ? SYM_ONE : SYM_ZERO;
            ST_TAIL:  sym = END_HIGH ? SYM_NDH : SYM_NDL;
            default:  sym = SYM_NDL;
        endcase
    end

    // Transmit sequencer: request capture, buffer load and frame sections.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            half       <= 1'b0;
            idx        <= '0;
            bits_last  <= '0;
            words_last <= '0;
            rk         <= '0;
            wk         <= '0;
            rd_pend    <= 1'b0;
            is_master  <= 1'b0;
            base       <= '0;
            shreg      <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        is_master <= req_master;
                        base      <= req_buf_addr;
                        rk        <= '0;
                        wk        <= '0;
                        half      <= 1'b0;
                        idx       <= '0;
                        unique case (req_len)
                            2'b00: begin
                                bits_last  <= 8'd15;
                                words_last <= 2'd0;
                                shreg      <= {req_data[15:0], 48'h0};
                            end
                            2'b01: begin
                                bits_last  <= 8'd31;
                                words_last <= 2'd1;
                                shreg      <= {req_data[31:0], 32'h0};
                            end
                            default: begin
                                bits_last  <= 8'd63;
                                words_last <= 2'd3;
                                shreg      <= req_data;
                            end
                        endcase
                        state <= req_from_buf ? ST_LOAD : ST_DELIM;
                    end
                end
                ST_LOAD: begin
                    rd_pend <= buf_rd_en;
                    if (buf_rd_en) rk <= rk + 3'd1;
                    if (rd_pend) begin
                        unique case (wk)
                            2'd0: shreg[63:48] <= buf_rdata;
                            2'd1: shreg[47:32] <= buf_rdata;
                            2'd2: shreg[31:16] <= buf_rdata;
                            default: shreg[15:0] <= buf_rdata;
                        endcase
                        wk <= wk + 2'd1;
                        if (wk == words_last) state <= ST_DELIM;
                    end
                end
                ST_DELIM: begin
                    if (tick) begin
                        half <= ~half;
                        if (half) begin
                            if (idx == DELIM_LAST) begin
                                idx   <= '0;
                                state <= ST_DATA;
                            end else idx <= idx + 8'd1;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        half <= ~half;
                        if (half) begin
                            shreg <= shreg << 1;
                            if (idx == bits_last) begin
                                idx   <= '0;
                                state <= ST_CHECK;
                            end else idx <= idx + 8'd1;
                        end
                    end
                end
                ST_CHECK: begin
                    if (tick) begin
                        half <= ~half;
                        if (half) begin
                            if (idx == CHECK_LAST) begin
                                idx   <= '0;
                                state <= ST_TAIL;
                            end else idx <= idx + 8'd1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (idx == TAIL_LAST) begin
                            idx   <= '0;
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else idx <= idx + 8'd1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mtx_frame_tx_chk.sv
// Port-level protocol checker for mtx_frame_tx, bound to every instance.
// Assumes: synchronous active-low reset, all checks disabled during reset.
module mtx_frame_tx_chk #(
    parameter int BUF_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              buf_rd_en,
    input logic [BUF_AW-1:0] buf_addr,
    input logic              line_out,
    input logic              busy,
    input logic              done
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R10
    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_out); // R9
    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> busy); // R7
    AST_READ_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_en && $past(buf_rd_en)) |-> (buf_addr == BUF_AW'($past(buf_addr) + 1'b1))); // R7
    AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)); // R2
endmodule

bind mtx_frame_tx mtx_frame_tx_chk #(.BUF_AW(BUF_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .buf_rd_en(buf_rd_en),
    .buf_addr(buf_addr), .line_out(line_out), .busy(busy), .done(done)
);

// File: tb/mtx_frame_tx_tb.sv
module mtx_frame_tx_tb;
    localparam logic [17:0] MDELIM = 18'b01_10_11_01_10_11_00_00_00;
    localparam logic [17:0] SDELIM = 18'b01_01_01_11_10_01_11_10_00;
    localparam int CELL_CLKS = 2;
    localparam int END_CELLS = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_master, req_from_buf;
    logic [1:0]  req_len;
    logic [63:0] req_data;
    logic [3:0]  req_buf_addr;
    logic        buf_rd_en;
    logic [3:0]  buf_addr;
    logic [15:0] buf_rdata;
    logic        line_out, busy, done;

    logic [15:0] mem [0:15];
    logic        exp_cells [0:199];
    int          n_cells;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    mtx_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_master(req_master),
        .req_len(req_len), .req_from_buf(req_from_buf), .req_data(req_data),
        .req_buf_addr(req_buf_addr), .buf_rd_en(buf_rd_en), .buf_addr(buf_addr),
        .buf_rdata(buf_rdata), .line_out(line_out), .busy(busy), .done(done)
    );

    // Shared buffer model with one-cycle read latency.
    always @(posedge clk) if (buf_rd_en) buf_rdata <= mem[buf_addr];

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
        end
    endtask

    function automatic logic [7:0] exp_check(input logic [63:0] p, input int nb);
        logic [6:0] r = '0;
        logic f;
        for (int i = nb - 1; i >= 0; i--) begin
            f = p[i] ^ r[6];
            r = {r[5:0], 1'b0} ^ (f ? 7'h65 : 7'h00);
        end
        return ~{r, ^r};
    endfunction

    task automatic push_bit(input logic a, input logic b);
        exp_cells[n_cells] = a; exp_cells[n_cells + 1] = b; n_cells += 2;
    endtask

    task automatic build(input bit master, input int nb, input logic [63:0] p);
        logic [17:0] d = master ? MDELIM : SDELIM;
        logic [1:0] code;
        logic [7:0] c = exp_check(p, nb);
        n_cells = 0;
        for (int s = 0; s < 9; s++) begin
            code = d[17 - 2*s -: 2];
            case (code)
                2'b00: push_bit(1'b0, 1'b1);
                2'b01: push_bit(1'b1, 1'b0);
                2'b10: push_bit(1'b1, 1'b1);
                default: push_bit(1'b0, 1'b0);
            endcase
        end
        for (int i = nb - 1; i >= 0; i--) push_bit(p[i], ~p[i]);
        for (int i = 7; i >= 0; i--) push_bit(c[i], ~c[i]);
        for (int i = 0; i < END_CELLS; i++) begin
            exp_cells[n_cells] = 1'b1; n_cells++;
        end
    endtask

    // Called at a negedge; returns at the negedge where done is expected high.
    task automatic run_frame(input bit master, input logic [1:0] lc, input bit fb,
                             input logic [63:0] d, input logic [3:0] addr, input bit poke);
        int nb = (lc == 2'b00) ? 16 : (lc == 2'b01) ? 32 : 64;
        int nw = nb / 16;
        logic [63:0] p;
        string tag;
        if (fb) begin
            p = '0;
            for (int k = 0; k < nw; k++) p = (p << 16) | 64'(mem[4'(addr + 4'(k))]);
        end else begin
            p = (nb == 64) ? d : (d & ((64'd1 << nb) - 1));
        end
        build(master, nb, p);
        req_valid = 1; req_master = master; req_len = lc; req_from_buf = fb;
        req_data = d; req_buf_addr = addr;
        @(negedge clk);
        req_valid = 0; req_data = {$urandom, $urandom};
        chk(busy == 1'b1, "R2 busy after accept", busy, 1);
        if (fb) begin
            for (int j = 0; j <= nw; j++) begin
                chk(buf_rd_en == (j < nw), "R7 read strobe", buf_rd_en, (j < nw));
                if (j < nw) chk(buf_addr == 4'(addr + 4'(j)), "R7 read address", buf_addr, 4'(addr + 4'(j)));
                chk(line_out == 1'b0, "R3 line idle during load", line_out, 0);
                @(negedge clk);
            end
        end
        for (int c = 0; c < n_cells; c++) begin
            for (int k = 0; k < CELL_CLKS; k++) begin
                if (poke && c == 30 && k == 0) begin
                    req_valid = 1; req_master = ~master; req_len = 2'b10;
                    req_from_buf = 0; req_data = ~d;
                end else req_valid = 0;
                if (c == 0) tag = "R3 first cell";
                else if (c < 18) tag = "R4 delimiter";
                else if (c < 18 + 2*nb) tag = "R5 R6 payload";
                else if (c < 34 + 2*nb) tag = "R8 check bits";
                else tag = "R9 end level";
                chk(line_out == exp_cells[c], tag, line_out, exp_cells[c]);
                if (!fb) chk(buf_rd_en == 1'b0, "R7 no read on direct", buf_rd_en, 0);
                @(negedge clk);
            end
        end
        req_valid = 0;
        chk(done == 1'b1, "R10 done at idle", done, 1);
        chk(busy == 1'b0, "R10 busy low with done", busy, 0);
        chk(line_out == 1'b0, "R9 line idle", line_out, 0);
    endtask

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R10 done single", done, 0);
            chk(busy == 1'b0, "R2 dropped request not queued", busy, 0);
            chk(line_out == 1'b0, "R9 idle line", line_out, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 0; req_valid = 0; req_master = 0; req_len = 0; req_from_buf = 0;
        req_data = '0; req_buf_addr = '0;
        for (int i = 0; i < 16; i++) mem[i] = 16'($urandom);
        repeat (3) @(negedge clk);
        chk(line_out == 0, "R1 reset line", line_out, 0);
        chk(busy == 0, "R1 reset busy", busy, 0);
        chk(done == 0, "R1 reset done", done, 0);
        chk(buf_rd_en == 0, "R1 reset read", buf_rd_en, 0);
        rst_n = 1;
        @(negedge clk);
        // Directed corner cases.
        run_frame(1, 2'b00, 0, 64'hFFFF_0000_1234_A5C3, 4'd0, 0); idle_gap(2);
        run_frame(0, 2'b01, 0, 64'h0F0F_F0F0_DEAD_BEEF, 4'd0, 0); idle_gap(2);
        run_frame(1, 2'b10, 1, '0, 4'd14, 0); idle_gap(2);            // R7 address wrap
        run_frame(0, 2'b00, 1, '0, 4'd0, 1); idle_gap(3);             // R2 request while busy
        run_frame(1, 2'b11, 0, 64'h8000_0000_0000_0001, 4'd0, 0);     // R6 code 11 as 64
        run_frame(0, 2'b10, 1, '0, 4'd5, 0); idle_gap(1);             // R10 request in done cycle
        run_frame(1, 2'b10, 0, 64'h0, 4'd0, 0);
        run_frame(0, 2'b10, 0, ~64'h0, 4'd0, 1); idle_gap(2);
        // Random frames.
        for (int f = 0; f < 20; f++) begin
            run_frame(1'($urandom), 2'($urandom % 4), 1'($urandom), {$urandom, $urandom},
                      4'($urandom), 1'($urandom));
            idle_gap($urandom % 3);
        end
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule